// File: doc/BRIEF.md
# CCD Pixel Reset and Correlated Double Sampling Strobe Generator

This block drives the per-pixel timing of a CCD video channel. A fast oversampling clock runs at N ticks per CCD element, and the element phase is locked to the falling edge of the phi2 shift clock. In each element the block first raises a reset-gate pulse, which returns the sense node to its reset level. It then raises a clamp strobe while the output shows the reset (feedthrough) level. Last, it raises a sample strobe while the output shows the video level. An external analog correlated double sampling stage uses the two strobes.

The position and width of each of the three pulses are programmed in fast-clock ticks, counted from the phi2 falling edge. A load is accepted only when the three pulses keep their order, keep the required gaps and fit inside one element. A rejected load leaves the running timing untouched. An accepted load takes effect at the start of the next element, so no element mixes two settings. While the line-transfer window input is high, the clamp and sample strobes are held low and the reset pulses continue.

Top module: `cdsg_top`

## Requirements
- R1: The element phase (tick) counts 0 to N-1 and wraps to 0. When `phi2_in` is sampled high on one clock edge and low on the next, the tick becomes 0 at that next edge, whatever its previous value.
- R2: `rst_gate` is high in exactly the ticks t for which rst_off <= t < rst_off + rst_len under the active setting, with one register of latency from the tick.
- R3: `clamp_stb` is high in the ticks clp_off <= t < clp_off + clp_len, and `sample_stb` is high in the ticks smp_off <= t < smp_off + smp_len, under the active setting.
- R4: No two of `rst_gate`, `clamp_stb` and `sample_stb` are high in the same cycle.
- R5: A load (`cfg_load` high for one cycle) is accepted only if all of these hold: rst_len >= MIN_RST; clp_len >= 1; smp_len >= 1; clp_off >= rst_off + rst_len + MIN_GAP; smp_off >= clp_off + clp_len + MIN_GAP; and smp_off + smp_len + MIN_GAP <= N. Otherwise `cfg_err` is high for one cycle, starting at the edge after the load, and the pending and active settings are unchanged.
- R6: When `xfer_win` is sampled high at a clock edge, `clamp_stb` and `sample_stb` are low after that edge. `rst_gate` is not affected.
- R7: An accepted setting first applies from the edge at which the tick returns to 0. Until that edge, the previous setting keeps driving all three outputs.
- R8: During and right after reset, all outputs are low. The active setting is rst 1/MIN_RST, clamp (1+MIN_RST+MIN_GAP)/(N/8), and sample (clamp end + MIN_GAP)/(N/8), each written as offset/length. With N=16, MIN_RST=2 and MIN_GAP=1 this gives rst 1/2, clamp 4/2 and sample 7/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock, N ticks per element |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2_in | input | 1 | phi2 shift clock level; its falling edge marks tick 0 |
| xfer_win | input | 1 | Line-transfer window; suppresses clamp and sample |
| cfg_load | input | 1 | One-cycle request to load the six timing fields |
| cfg_rst_off | input | 8 | Reset pulse start tick |
| cfg_rst_len | input | 8 | Reset pulse width in ticks |
| cfg_clp_off | input | 8 | Clamp strobe start tick |
| cfg_clp_len | input | 8 | Clamp strobe width in ticks |
| cfg_smp_off | input | 8 | Sample strobe start tick |
| cfg_smp_len | input | 8 | Sample strobe width in ticks |
| rst_gate | output | 1 | Reset gate pulse |
| clamp_stb | output | 1 | Clamp strobe on the reset level |
| sample_stb | output | 1 | Sample strobe on the video level |
| cfg_err | output | 1 | One-cycle flag for a rejected load |

## Verification
The bench builds the block with N=16, MIN_RST=2 and MIN_GAP=1. With a 16-tick element, every load becomes due within a few cycles. This lets the bench reach the exact edge case where the sample strobe ends MIN_GAP ticks before the element boundary, and the case one tick past it. It also keeps phi2 resynchronisation, both early and late against the free-running count, within short runs. The small MIN_RST and MIN_GAP values let both sides of each spacing rule be hit with single-tick changes to a setting.

// File: rtl/cdsg_pkg.sv
package cdsg_pkg;
    localparam int FW = 8;

    typedef struct packed {
        logic [FW-1:0] rst_off;
        logic [FW-1:0] rst_len;
        logic [FW-1:0] clp_off;
        logic [FW-1:0] clp_len;
        logic [FW-1:0] smp_off;
        logic [FW-1:0] smp_len;
    } strobe_cfg_t;
endpackage

// File: rtl/cdsg_phase.sv
module cdsg_phase #(
    parameter int N  = 16,
    parameter int TW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phi2_in,
    output logic [TW-1:0] tick_nxt,
    output logic [TW-1:0] tick_cur
);
    localparam logic [TW-1:0] LAST = TW'(N - 1);

    typedef struct packed {
        logic          phi2;
        logic [TW-1:0] tick;
    } phase_t;

    phase_t s_d, s_q;
    logic   fall;

    always_comb begin
        s_d      = s_q;
        fall     = s_q.phi2 & ~phi2_in;
        s_d.phi2 = phi2_in;
        if (fall || s_q.tick == LAST) begin
            s_d.tick = '0;
        end else begin
            s_d.tick = s_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_nxt = s_d.tick;
    assign tick_cur = s_q.tick;

    // R1: tick never leaves the element range
    p_tick_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tick <= LAST);

    // R1: a detected phi2 fall restarts the element phase
    p_phase_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> s_q.tick == '0);
endmodule

// File: rtl/cdsg_cfg_check.sv
module cdsg_cfg_check
    import cdsg_pkg::*;
#(
    parameter int N       = 16,
    parameter int MIN_RST = 2,
    parameter int MIN_GAP = 1
) (
    input  strobe_cfg_t cfg,
    output logic        ok
);
    localparam int XW = FW + 2;
    localparam logic [XW-1:0] NX   = XW'(N);
    localparam logic [XW-1:0] RSTX = XW'(MIN_RST);
    localparam logic [XW-1:0] GAPX = XW'(MIN_GAP);

    logic [XW-1:0] r_off, r_len, c_off, c_len, s_off, s_len;
    logic          len_ok, clamp_ok, samp_ok, fit_ok;

    always_comb begin
        r_off    = XW'(cfg.rst_off);
        r_len    = XW'(cfg.rst_len);
        c_off    = XW'(cfg.clp_off);
        c_len    = XW'(cfg.clp_len);
        s_off    = XW'(cfg.smp_off);
        s_len    = XW'(cfg.smp_len);
        len_ok   = (r_len >= RSTX) && (c_len != '0) && (s_len != '0);
        clamp_ok = c_off >= r_off + r_len + GAPX;
        samp_ok  = s_off >= c_off + c_len + GAPX;
        fit_ok   = s_off + s_len + GAPX <= NX;
        ok       = len_ok && clamp_ok && samp_ok && fit_ok;
    end
endmodule

// File: rtl/cdsg_window.sv
module cdsg_window
    import cdsg_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic [TW-1:0] tick,
    input  logic [FW-1:0] off,
    input  logic [FW-1:0] len,
    output logic          hit
);
    localparam int XW = FW + 2;

    logic [XW-1:0] t_x, lo_x, hi_x;

    always_comb begin
        t_x  = XW'(tick);
        lo_x = XW'(off);
        hi_x = XW'(off) + XW'(len);
        hit  = (t_x >= lo_x) && (t_x < hi_x);
    end
endmodule

// File: rtl/cdsg_top.sv
module cdsg_top
    import cdsg_pkg::*;
#(
    parameter int N       = 16,
    parameter int MIN_RST = 2,
    parameter int MIN_GAP = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phi2_in,
    input  logic          xfer_win,
    input  logic          cfg_load,
    input  logic [FW-1:0] cfg_rst_off,
    input  logic [FW-1:0] cfg_rst_len,
    input  logic [FW-1:0] cfg_clp_off,
    input  logic [FW-1:0] cfg_clp_len,
    input  logic [FW-1:0] cfg_smp_off,
    input  logic [FW-1:0] cfg_smp_len,
    output logic          rst_gate,
    output logic          clamp_stb,
    output logic          sample_stb,
    output logic          cfg_err
);
    localparam int TW     = $clog2(N);
    localparam int NSTB   = 3;
    localparam int STB_LN = (N / 8 < 1) ? 1 : N / 8;
    localparam int D_ROFF = 1;
    localparam int D_COFF = D_ROFF + MIN_RST + MIN_GAP;
    localparam int D_SOFF = D_COFF + STB_LN + MIN_GAP;

    localparam strobe_cfg_t DEF_CFG = '{
        rst_off: FW'(D_ROFF), rst_len: FW'(MIN_RST),
        clp_off: FW'(D_COFF), clp_len: FW'(STB_LN),
        smp_off: FW'(D_SOFF), smp_len: FW'(STB_LN)
    };

    typedef struct packed {
        strobe_cfg_t act;
        strobe_cfg_t pend;
        logic        pend_v;
        logic        rst;
        logic        clp;
        logic        smp;
        logic        err;
    } top_state_t;

    localparam top_state_t RST_STATE = '{
        act: DEF_CFG, pend: DEF_CFG, pend_v: 1'b0,
        rst: 1'b0, clp: 1'b0, smp: 1'b0, err: 1'b0
    };

    top_state_t    s_d, s_q;
    strobe_cfg_t   cfg_in, act_nxt;
    logic          in_ok, act_ok, apply;
    logic [TW-1:0] tick_nxt, tick_cur;
    logic [FW-1:0] w_off [NSTB];
    logic [FW-1:0] w_len [NSTB];
    logic [NSTB-1:0] hit;

    assign cfg_in = '{
        rst_off: cfg_rst_off, rst_len: cfg_rst_len,
        clp_off: cfg_clp_off, clp_len: cfg_clp_len,
        smp_off: cfg_smp_off, smp_len: cfg_smp_len
    };

    cdsg_phase #(.N(N), .TW(TW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .phi2_in  (phi2_in),
        .tick_nxt (tick_nxt),
        .tick_cur (tick_cur)
    );

    cdsg_cfg_check #(.N(N), .MIN_RST(MIN_RST), .MIN_GAP(MIN_GAP)) u_chk_in (
        .cfg (cfg_in),
        .ok  (in_ok)
    );

    // second checker watches the running setting for the assertion below
    cdsg_cfg_check #(.N(N), .MIN_RST(MIN_RST), .MIN_GAP(MIN_GAP)) u_chk_act (
        .cfg (s_q.act),
        .ok  (act_ok)
    );

    assign apply   = (tick_nxt == '0) && s_q.pend_v;
    assign act_nxt = apply ? s_q.pend : s_q.act;

    assign w_off[0] = act_nxt.rst_off;
    assign w_len[0] = act_nxt.rst_len;
    assign w_off[1] = act_nxt.clp_off;
    assign w_len[1] = act_nxt.clp_len;
    assign w_off[2] = act_nxt.smp_off;
    assign w_len[2] = act_nxt.smp_len;

    for (genvar g = 0; g < NSTB; g++) begin : g_win
        cdsg_window #(.TW(TW)) u_win (
            .tick (tick_nxt),
            .off  (w_off[g]),
            .len  (w_len[g]),
            .hit  (hit[g])
        );
    end

    always_comb begin
        s_d = s_q;
        if (apply) begin
            s_d.act    = s_q.pend;
            s_d.pend_v = 1'b0;
        end
        if (cfg_load && in_ok) begin
            s_d.pend   = cfg_in;
            s_d.pend_v = 1'b1;
        end
        s_d.err = cfg_load && !in_ok;
        s_d.rst = hit[0];
        s_d.clp = hit[1] && !xfer_win;
        s_d.smp = hit[2] && !xfer_win;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= RST_STATE;
        end else begin
            s_q <= s_d;
        end
    end

    assign rst_gate   = s_q.rst;
    assign clamp_stb  = s_q.clp;
    assign sample_stb = s_q.smp;
    assign cfg_err    = s_q.err;

    // R4: the three pulses never coincide
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rst_gate, clamp_stb, sample_stb}) <= 1);

    // R5: the running setting always obeys the spacing rules
    p_active_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act_ok);

    // R5: a rejected load leaves the pending setting as it was
    p_reject_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> s_q.pend == $past(s_q.pend));

    // R6: transfer window blocks both sampling strobes
    p_xfer_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xfer_win) |-> !clamp_stb && !sample_stb);

    // R7: a pending setting takes over exactly at the element start
    p_apply_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(s_q.pend_v) && tick_cur == '0 |-> s_q.act == $past(s_q.pend));
endmodule

// File: tb/tb_cdsg_top.sv
module tb_cdsg_top;
    localparam int N       = 16;
    localparam int MIN_RST = 2;
    localparam int MIN_GAP = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phi2_in = 1'b0;
    logic       xfer_win = 1'b0;
    logic       cfg_load = 1'b0;
    logic [7:0] c_ro = 8'd0, c_rl = 8'd0, c_co = 8'd0, c_cl = 8'd0, c_so = 8'd0, c_sl = 8'd0;
    logic       rst_gate, clamp_stb, sample_stb, cfg_err;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string ctx = "R2 R3 default";

    always #5 clk = ~clk;

    cdsg_top #(.N(N), .MIN_RST(MIN_RST), .MIN_GAP(MIN_GAP)) dut (
        .clk(clk), .rst_n(rst_n), .phi2_in(phi2_in), .xfer_win(xfer_win),
        .cfg_load(cfg_load),
        .cfg_rst_off(c_ro), .cfg_rst_len(c_rl),
        .cfg_clp_off(c_co), .cfg_clp_len(c_cl),
        .cfg_smp_off(c_so), .cfg_smp_len(c_sl),
        .rst_gate(rst_gate), .clamp_stb(clamp_stb),
        .sample_stb(sample_stb), .cfg_err(cfg_err)
    );

    // reference model state
    int m_tick, m_prev;
    int act[6];
    int pend[6];
    int pend_v;
    bit e_rst, e_clp, e_smp, e_err;

    function automatic bit rules_ok(int ro, int rl, int co, int cl, int so, int sl);
        if (rl < MIN_RST || cl < 1 || sl < 1) return 1'b0;
        if (co < ro + rl + MIN_GAP) return 1'b0;
        if (so < co + cl + MIN_GAP) return 1'b0;
        if (so + sl + MIN_GAP > N) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit inside_win(int t, int off, int len);
        return (t >= off) && (t < off + len);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tick = 0; m_prev = 0; pend_v = 0;
            act = '{1, 2, 4, 2, 7, 2};
            pend = act;
            e_rst = 0; e_clp = 0; e_smp = 0; e_err = 0;
        end else begin
            int  nt;
            bit  ok;
            bit  due;
            nt = (m_prev == 1 && !phi2_in) ? 0 : ((m_tick == N - 1) ? 0 : m_tick + 1);
            m_prev = int'(phi2_in);
            ok = rules_ok(c_ro, c_rl, c_co, c_cl, c_so, c_sl);
            due = (nt == 0) && (pend_v == 1);
            if (due) begin
                act = pend;
                pend_v = 0;
            end
            if (cfg_load && ok) begin
                pend = '{int'(c_ro), int'(c_rl), int'(c_co), int'(c_cl), int'(c_so), int'(c_sl)};
                pend_v = 1;
            end
            e_err = cfg_load && !ok;
            m_tick = nt;
            e_rst = inside_win(nt, act[0], act[1]);
            e_clp = inside_win(nt, act[2], act[3]) && !xfer_win;
            e_smp = inside_win(nt, act[4], act[5]) && !xfer_win;
        end
    end

    task automatic chk(bit got, bit exp, string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s [%s] got=%0b exp=%0b t=%0t", what, ctx, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk(rst_gate | clamp_stb | sample_stb | cfg_err, 1'b0, "R8 outputs low in reset");
            end else begin
                chk(rst_gate, e_rst, "R2 rst_gate");
                chk(clamp_stb, e_clp, "R3/R6 clamp_stb");
                chk(sample_stb, e_smp, "R3/R6 sample_stb");
                chk(cfg_err, e_err, "R5 cfg_err");
                chk(($countones({rst_gate, clamp_stb, sample_stb}) > 1), 1'b0, "R4 no overlap");
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic load(int ro, int rl, int co, int cl, int so, int sl);
        c_ro = 8'(ro); c_rl = 8'(rl); c_co = 8'(co);
        c_cl = 8'(cl); c_so = 8'(so); c_sl = 8'(sl);
        cfg_load = 1'b1;
        step(1);
        cfg_load = 1'b0;
    endtask

    task automatic phi2_period(int hi, int lo, int reps);
        for (int i = 0; i < reps; i++) begin
            phi2_in = 1'b1;
            step(hi);
            phi2_in = 1'b0;
            step(lo);
        end
    endtask

    initial begin
        ctx = "R8 reset";
        step(3);
        rst_n = 1'b1;
        ctx = "R8 first element after reset, defaults";
        step(2 * N);

        ctx = "R1 phi2 locked at element rate";
        phi2_period(N / 2, N / 2, 3);
        ctx = "R1 early phi2 fall truncates element";
        phi2_period(3, 6, 3);
        ctx = "R1 late phi2 fall, free wrap first";
        phi2_period(10, 12, 2);

        ctx = "R7 deferred load";
        step(5);
        load(0, 2, 4, 3, 9, 4);
        step(2 * N);

        ctx = "R5 rejected: clamp too close to reset";
        load(2, 3, 5, 2, 9, 2);
        step(N);
        ctx = "R5 rejected: sample past element end";
        load(0, 2, 3, 2, 12, 4);
        step(N);
        ctx = "R5 rejected: reset pulse too short";
        load(1, 1, 4, 2, 8, 2);
        step(N);
        ctx = "R5 rejected: zero clamp width";
        load(1, 2, 5, 0, 8, 2);
        step(N);

        ctx = "R5 boundary: sample ends MIN_GAP before element end";
        load(0, 2, 3, 1, 5, 10);
        step(2 * N);
        ctx = "R5 rejected: one tick past the boundary";
        load(0, 2, 3, 1, 5, 11);
        step(2 * N);

        ctx = "R6 transfer window";
        xfer_win = 1'b1;
        step(2 * N + 3);
        xfer_win = 1'b0;
        step(N);

        ctx = "R7 two loads in one element, last wins";
        load(1, 3, 6, 2, 10, 3);
        load(2, 2, 5, 4, 11, 2);
        step(2 * N);

        ctx = "R6 R1 transfer with phi2 resync";
        xfer_win = 1'b1;
        phi2_period(4, 5, 2);
        xfer_win = 1'b0;
        step(N);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule